// File: doc/BRIEF.md
# Vertical Blanking Interval Gate

This block decides, once per video line, whether the content of that line reaches the video output or is replaced by blanking. It handles the lines of the vertical blanking interval. Each of the four supported scan standards defines its own range of lines on which inserted data such as copy-protection or aspect-ratio signalling may be carried. Lines below that range are always blanked. Lines inside the range pass only when the controls allow it. Lines after the range are active picture and always pass.

The controls are as follows. There are two separate enable bits, one for the interlaced (standard-definition) path and one for the progressive path. A timing-mode select also shapes the result: two of the slave modes additionally require a blanking-control enable. Copy-protection lines are let through whenever their own enable is set, even when the interval is otherwise disabled. In the first slave mode, a permitted interval line also forces the blanking bit of the embedded timing codes to "active".

The line counter that drives the block sits upstream and supplies a line-start strobe. For interlaced standards the line number is counted within the field; for progressive standards it is counted within the frame. Numbers are 1-based. The decision is captured on the strobe and held for the whole line.

Top module: `vbi_gate`

## Requirements
- R1: After reset `pass_line` is 1, and `blank_bit_out` equals `blank_bit_in`.
- R2: The permitted window is inclusive at both ends. Encoded by `std_sel`: 0 = 525-line interlaced, lines 10..20; 1 = 625-line interlaced, lines 7..22; 2 = 525p, lines 13..42; 3 = 625p, lines 6..43. A window line passes when the applicable enable is set and the mode is master.
- R3: A line numbered above the window end passes, whatever the other controls are.
- R4: A line numbered below the window start (line 0 included) is blanked unless the copy-protection rule of R8 applies.
- R5: With the applicable enable clear, every window line is blanked in all four timing modes, unless R8 applies.
- R6: Interlaced standards (`std_sel` 0,1) use `vbi_en_sd` only. Progressive standards (2,3) use `vbi_en_hd` only.
- R7: `tmode` encoding: 0 = slave 0, 1 = slave 1, 2 = slave 2, 3 = master. In modes 1 and 2 a window line passes only if `blank_ctl_en` is also 1. In modes 0 and 3, `blank_ctl_en` has no effect.
- R8: When `cgms_en` and `cgms_line` are both 1 on any line not above the window end, the line passes, regardless of the enables, the mode and `blank_ctl_en`.
- R9: For a line latched in mode 0 with the applicable enable set and the line inside the window, `blank_bit_out` is 0 for the whole line. On every other line it equals `blank_bit_in`.
- R10: `pass_line` and the blanking-bit override are updated one clock after `line_start` is sampled high. Between strobes they do not change, even if any input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle strobe marking the start of a line |
| line_num | input | LINE_W | 1-based line number (per field interlaced, per frame progressive) |
| std_sel | input | 2 | Scan standard select |
| tmode | input | 2 | Timing mode select |
| vbi_en_sd | input | 1 | Interval enable for interlaced standards |
| vbi_en_hd | input | 1 | Interval enable for progressive standards |
| blank_ctl_en | input | 1 | Blanking-control enable needed in slave modes 1 and 2 |
| cgms_en | input | 1 | Copy-protection line pass enable |
| cgms_line | input | 1 | Current line carries copy-protection data |
| blank_bit_in | input | 1 | Blanking bit of the incoming embedded timing code |
| pass_line | output | 1 | 1 = pass line content, 0 = substitute blanking |
| blank_bit_out | output | 1 | Blanking bit for the outgoing embedded timing code |

## Verification
The bench probes the first and last line of every window and the lines just beyond each end. A window with an off-by-one bound, or a swapped window between standards, then shows up as a wrong decision on exactly those lines. It crosses the two enable bits with interlaced and progressive standards, which catches a design that reads the wrong enable. It runs all four timing modes with the blanking-control bit both set and clear, which exposes a design that applies that bit in the wrong modes. Copy-protection lines are sent with the interval disabled. The bench also changes inputs in the middle of a line, to catch a decision that is not held, and checks that the blanking-bit override appears in slave mode 0 only.

// File: rtl/vbi_gate_pkg.sv
package vbi_gate_pkg;

  typedef enum logic [1:0] {
    STD_525I = 2'd0,
    STD_625I = 2'd1,
    STD_525P = 2'd2,
    STD_625P = 2'd3
  } vstd_e;

  typedef enum logic [1:0] {
    TM_SLAVE0 = 2'd0,
    TM_SLAVE1 = 2'd1,
    TM_SLAVE2 = 2'd2,
    TM_MASTER = 2'd3
  } tmode_e;

  // first line on which interval data may pass
  function automatic logic [31:0] win_first(vstd_e s);
    case (s)
      STD_525I: win_first = 32'd10;
      STD_625I: win_first = 32'd7;
      STD_525P: win_first = 32'd13;
      default:  win_first = 32'd6;
    endcase
  endfunction

  // last line of the interval window
  function automatic logic [31:0] win_last(vstd_e s);
    case (s)
      STD_525I: win_last = 32'd20;
      STD_625I: win_last = 32'd22;
      STD_525P: win_last = 32'd42;
      default:  win_last = 32'd43;
    endcase
  endfunction

  function automatic logic is_prog(vstd_e s);
    is_prog = (s == STD_525P) || (s == STD_625P);
  endfunction

  // slave modes 1 and 2 need the blanking-control bit
  function automatic logic needs_blank_ctl(tmode_e m);
    needs_blank_ctl = (m == TM_SLAVE1) || (m == TM_SLAVE2);
  endfunction

endpackage

// File: rtl/vbi_window.sv
module vbi_window
  import vbi_gate_pkg::*;
#(
  parameter int LINE_W = 11
) (
  input  logic [LINE_W-1:0] line_num,
  input  vstd_e             std,
  output logic              below_win,
  output logic              in_win,
  output logic              above_win
);
  logic [31:0] ln;
  logic [31:0] lo;
  logic [31:0] hi;

  assign ln = 32'(line_num);
  assign lo = win_first(std);
  assign hi = win_last(std);

  assign below_win = ln < lo;
  assign above_win = ln > hi;
  assign in_win    = !below_win && !above_win;
endmodule

// File: rtl/vbi_policy.sv
module vbi_policy
  import vbi_gate_pkg::*;
(
  input  vstd_e  std,
  input  tmode_e mode,
  input  logic   vbi_en_sd,
  input  logic   vbi_en_hd,
  input  logic   blank_ctl_en,
  input  logic   cgms_en,
  input  logic   cgms_line,
  input  logic   below_win,
  input  logic   in_win,
  input  logic   above_win,
  output logic   en_eff,
  output logic   mode_ok,
  output logic   cgms_ok,
  output logic   pass_d,
  output logic   ovr_d
);
  logic vbi_ok;

  assign en_eff  = is_prog(std) ? vbi_en_hd : vbi_en_sd;
  assign mode_ok = needs_blank_ctl(mode) ? blank_ctl_en : 1'b1;
  assign cgms_ok = cgms_en && cgms_line && !above_win;
  assign vbi_ok  = en_eff && mode_ok && in_win;

  always_comb begin
    if (above_win)      pass_d = 1'b1;
    else if (cgms_ok)   pass_d = 1'b1;
    else if (below_win) pass_d = 1'b0;
    else                pass_d = vbi_ok;
  end

  assign ovr_d = (mode == TM_SLAVE0) && en_eff && in_win;
endmodule

// File: rtl/vbi_gate.sv
module vbi_gate
  import vbi_gate_pkg::*;
#(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_num,
  input  logic [1:0]        std_sel,
  input  logic [1:0]        tmode,
  input  logic              vbi_en_sd,
  input  logic              vbi_en_hd,
  input  logic              blank_ctl_en,
  input  logic              cgms_en,
  input  logic              cgms_line,
  input  logic              blank_bit_in,
  output logic              pass_line,
  output logic              blank_bit_out
);
  vstd_e  std;
  tmode_e mode;
  logic   below_win, in_win, above_win;
  logic   en_eff, mode_ok, cgms_ok, pass_d, ovr_d;
  logic   pass_q, ovr_q;

  assign std  = vstd_e'(std_sel);
  assign mode = tmode_e'(tmode);

  vbi_window #(.LINE_W(LINE_W)) u_win (
    .line_num  (line_num),
    .std       (std),
    .below_win (below_win),
    .in_win    (in_win),
    .above_win (above_win)
  );

  vbi_policy u_pol (
    .std          (std),
    .mode         (mode),
    .vbi_en_sd    (vbi_en_sd),
    .vbi_en_hd    (vbi_en_hd),
    .blank_ctl_en (blank_ctl_en),
    .cgms_en      (cgms_en),
    .cgms_line    (cgms_line),
    .below_win    (below_win),
    .in_win       (in_win),
    .above_win    (above_win),
    .en_eff       (en_eff),
    .mode_ok      (mode_ok),
    .cgms_ok      (cgms_ok),
    .pass_d       (pass_d),
    .ovr_d        (ovr_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pass_q <= 1'b1;
      ovr_q  <= 1'b0;
    end else if (line_start) begin
      pass_q <= pass_d;
      ovr_q  <= ovr_d;
    end
  end

  assign pass_line     = pass_q;
  assign blank_bit_out = ovr_q ? 1'b0 : blank_bit_in;

  // R10
  mid_line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(pass_line));

  // R3
  active_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && above_win) |=> pass_line);

  // R4
  below_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && below_win && !cgms_line) |=> !pass_line);

  // R5
  disabled_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && in_win && !en_eff && !cgms_line) |=> !pass_line);

  // R9
  master_blank_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && mode == TM_MASTER) |=> (blank_bit_out == blank_bit_in));

  // R8
  cgms_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && cgms_en && cgms_line) |=> pass_line);
endmodule

// File: tb/tb_vbi_gate.sv
`timescale 1ns/1ps
module tb_vbi_gate;
  localparam int LINE_W = 11;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              line_start;
  logic [LINE_W-1:0] line_num;
  logic [1:0]        std_sel, tmode;
  logic              vbi_en_sd, vbi_en_hd, blank_ctl_en, cgms_en, cgms_line, blank_bit_in;
  logic              pass_line, blank_bit_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vbi_gate #(.LINE_W(LINE_W)) dut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
    .std_sel(std_sel), .tmode(tmode), .vbi_en_sd(vbi_en_sd), .vbi_en_hd(vbi_en_hd),
    .blank_ctl_en(blank_ctl_en), .cgms_en(cgms_en), .cgms_line(cgms_line),
    .blank_bit_in(blank_bit_in), .pass_line(pass_line), .blank_bit_out(blank_bit_out)
  );

  function automatic int lo_of(int s);
    int t[4] = '{10, 7, 13, 6};
    return t[s];
  endfunction
  function automatic int hi_of(int s);
    int t[4] = '{20, 22, 42, 43};
    return t[s];
  endfunction

  // expected decision restated from the requirements
  function automatic bit exp_pass(int s, int m, int ln, bit esd, bit ehd, bit bc, bit ce, bit cl);
    bit en;
    if (ln > hi_of(s)) return 1;
    if (ce && cl) return 1;
    if (ln < lo_of(s)) return 0;
    en = (s >= 2) ? ehd : esd;
    if (!en) return 0;
    if ((m == 1 || m == 2) && !bc) return 0;
    return 1;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // present a line: inputs at negedge, strobe captured at next posedge,
  // result sampled at the following negedge
  task automatic run_line(int s, int m, int ln, bit esd, bit ehd, bit bc, bit ce, bit cl);
    @(negedge clk);
    std_sel = 2'(s); tmode = 2'(m); line_num = LINE_W'(ln);
    vbi_en_sd = esd; vbi_en_hd = ehd; blank_ctl_en = bc; cgms_en = ce; cgms_line = cl;
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
  endtask

  task automatic line_chk(string req, int s, int m, int ln, bit esd, bit ehd, bit bc, bit ce, bit cl);
    run_line(s, m, ln, esd, ehd, bc, ce, cl);
    check(req, $sformatf("std%0d mode%0d line%0d", s, m, ln), int'(pass_line),
          int'(exp_pass(s, m, ln, esd, ehd, bc, ce, cl)));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; line_start = 0; line_num = '0; std_sel = 0; tmode = 3;
    vbi_en_sd = 0; vbi_en_hd = 0; blank_ctl_en = 0; cgms_en = 0; cgms_line = 0; blank_bit_in = 1;
    repeat (3) @(negedge clk);
    check("R1", "reset pass", int'(pass_line), 1);
    check("R1", "reset blank bit", int'(blank_bit_out), 1);
    blank_bit_in = 0; #1;
    check("R1", "reset blank bit follows", int'(blank_bit_out), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_windows();
    for (int s = 0; s < 4; s++) begin
      line_chk("R2", s, 3, lo_of(s), 1, 1, 0, 0, 0);
      line_chk("R2", s, 3, hi_of(s), 1, 1, 0, 0, 0);
      line_chk("R4", s, 3, lo_of(s) - 1, 1, 1, 0, 0, 0);
      line_chk("R3", s, 3, hi_of(s) + 1, 0, 0, 0, 0, 0);
    end
    line_chk("R4", 2, 3, 0, 1, 1, 1, 0, 0);
    line_chk("R3", 1, 1, 300, 0, 0, 0, 0, 0);
  endtask

  task automatic t_disable();
    for (int m = 0; m < 4; m++) begin
      line_chk("R5", 0, m, 15, 0, 1, 1, 0, 0);
      line_chk("R5", 3, m, 20, 1, 0, 1, 0, 0);
    end
  endtask

  task automatic t_enable_select();
    line_chk("R6", 1, 3, 10, 1, 0, 0, 0, 0);
    line_chk("R6", 1, 3, 10, 0, 1, 0, 0, 0);
    line_chk("R6", 2, 3, 30, 0, 1, 0, 0, 0);
    line_chk("R6", 2, 3, 30, 1, 0, 0, 0, 0);
  endtask

  task automatic t_modes();
    for (int m = 0; m < 4; m++) begin
      line_chk("R7", 0, m, 12, 1, 0, 0, 0, 0);
      line_chk("R7", 3, m, 25, 0, 1, 1, 0, 0);
    end
  endtask

  task automatic t_cgms();
    line_chk("R8", 0, 3, 15, 0, 0, 0, 1, 1);
    line_chk("R8", 2, 1, 5, 0, 0, 0, 1, 1);
    line_chk("R8", 1, 2, 12, 0, 0, 0, 1, 0);
    line_chk("R8", 1, 2, 12, 0, 0, 0, 0, 1);
  endtask

  task automatic t_blank_bit();
    run_line(0, 0, 15, 1, 0, 0, 0, 0);
    blank_bit_in = 1; #1;
    check("R9", "slave0 window override", int'(blank_bit_out), 0);
    run_line(0, 1, 15, 1, 0, 1, 0, 0);
    blank_bit_in = 1; #1;
    check("R9", "slave1 no override", int'(blank_bit_out), 1);
    run_line(2, 0, 15, 1, 0, 0, 0, 0);
    blank_bit_in = 1; #1;
    check("R9", "slave0 wrong enable", int'(blank_bit_out), 1);
    run_line(0, 0, 25, 1, 0, 0, 0, 0);
    blank_bit_in = 1; #1;
    check("R9", "slave0 above window", int'(blank_bit_out), 1);
    blank_bit_in = 0; #1;
    check("R9", "follows input", int'(blank_bit_out), 0);
  endtask

  task automatic t_hold();
    run_line(0, 3, 5, 1, 0, 0, 0, 0);
    check("R10", "latched blank", int'(pass_line), 0);
    @(negedge clk);
    line_num = 11'd100; vbi_en_sd = 1; cgms_en = 1; cgms_line = 1;
    repeat (3) @(negedge clk);
    check("R10", "held mid line", int'(pass_line), 0);
    run_line(0, 0, 15, 1, 0, 0, 0, 0);
    @(negedge clk);
    tmode = 3; blank_bit_in = 1;
    repeat (2) @(negedge clk);
    check("R10", "override held", int'(blank_bit_out), 0);
  endtask

  initial begin
    t_reset();
    t_windows();
    t_disable();
    t_enable_select();
    t_modes();
    t_cgms();
    t_blank_bit();
    t_hold();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule